// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces addresses for indirect memory accesses. It keeps a number of pointer contexts. Each context holds a current pointer, a step, a window start and a window size. Every access emits the current pointer and then advances it by the step. When a window size is set, the pointer stays inside a buffer that can start at any address and can have any size, with no power-of-two restriction. A pointer that steps past either edge of the window comes back in from the other edge, and no software correction is needed.

Each context exists twice, in a primary bank and a secondary bank. The bank input of each port picks which copy it uses in that same cycle, so a task switch does not have to save and reload registers. For FFT data reordering, an access can ask for the emitted address to have a chosen number of its low bits mirrored. The stored pointer still advances in the normal way. The step of one access can be replaced by an immediate value given on the access port.

Top module: `dag_addr_gen`

## Requirements
- R1: While reset is held, and after it is released, `addr_valid` is 0 and `addr_out` is 0. Every pointer, step, window start and window size register in both banks reads as 0 after reset.
- R2: When `acc_en` is 1 at a rising edge, `addr_valid` is 1 in the following cycle and `addr_out` holds the emitted address. When `acc_en` is 0, `addr_valid` goes to 0 in the following cycle and `addr_out` keeps its value.
- R3: An access with `acc_imm_en`=0 emits the pointer of the selected context and then sets the pointer to pointer plus the stored step. The step is a two's-complement value.
- R4: An access with `acc_imm_en`=1 uses `acc_imm` (two's complement) as its step in place of the stored step, and the stored step is left unchanged.
- R5: With a nonzero window size L and window start B, a stepped pointer that is at or above B+L is reduced by L.
- R6: With a nonzero window size, a stepped pointer that is below B is increased by L. Wrapping is correct when the step magnitude is at most L and the pointer starts inside the window.
- R7: A window size of 0 gives plain linear stepping, modulo 2^AW.
- R8: With `acc_rev_en`=1, the emitted address is the pointer with bits [N-1:0] reversed in order (bit k takes bit N-1-k), where N=`rev_bits`, and the bits above N unchanged. A value of N larger than AW acts as AW. The pointer still advances by R3 to R7.
- R9: A register write uses the field code on `wr_field`: 0 = pointer, 1 = step, 2 = window start, 3 = window size. Writing the window start also loads the pointer with the same value.
- R10: `wr_bank` and `acc_bank` select the primary copy (0) or the secondary copy (1) of a context in the same cycle. Writes and accesses on one bank or one context leave every other copy unchanged.
- R11: When a write to the pointer or to the window start of a context hits the same cycle as an access to that context and bank, the access emits the old pointer and the written value becomes the new pointer. The written value takes precedence over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | SW | Context selected for the write |
| wr_bank | input | 1 | Bank for the write (0 primary, 1 secondary) |
| wr_field | input | 2 | Register field code (R9) |
| wr_data | input | AW | Value written |
| acc_en | input | 1 | Access strobe |
| acc_set | input | SW | Context selected for the access |
| acc_bank | input | 1 | Bank for the access |
| acc_imm_en | input | 1 | Use the immediate step for this access |
| acc_imm | input | AW | Immediate step, two's complement |
| acc_rev_en | input | 1 | Emit the bit-reversed address |
| rev_bits | input | RBW | Number of low bits to reverse |
| addr_out | output | AW | Emitted address, registered |
| addr_valid | output | 1 | High in the cycle after an access |

## Verification
Directed sequences drive a pointer across the upper edge and, with a negative immediate step, across the lower edge. These sequences show whether each wrap direction adds or removes the window size, and whether a window size of 0 falls back to linear stepping with 16-bit rollover. Random windows, with arbitrary starts, sizes from 1 to 64 and steps of either sign bounded by the size, are mixed with random bit-reverse widths and random bank and context choices. These runs separate a correct modulo update from a mask-based update, and a correct mirror width from an off-by-one. Bank and context crosstalk is exposed by reading back contexts that other traffic did not touch, and a same-cycle write and access shows which source wins the pointer update.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    FLD_PTR  = 2'd0,
    FLD_STEP = 2'd1,
    FLD_BASE = 2'd2,
    FLD_SIZE = 2'd3
  } dag_field_e;
endpackage

// File: rtl/dag_rst_sync.sv
module dag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/dag_regfile.sv
module dag_regfile
  import dag_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NSETS = 8,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic          wr_bank,
  input  dag_field_e    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic          upd_bank,
  input  logic [AW-1:0] upd_ptr,
  input  logic [SW-1:0] rd_set,
  input  logic          rd_bank,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] rd_step,
  output logic [AW-1:0] rd_base,
  output logic [AW-1:0] rd_size
);
  localparam int NSLOT = 2 * NSETS;

  logic [AW-1:0] ptr_a  [NSLOT];
  logic [AW-1:0] step_a [NSLOT];
  logic [AW-1:0] base_a [NSLOT];
  logic [AW-1:0] size_a [NSLOT];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      localparam int SL = b * NSETS + s;
      logic          wr_hit;
      logic          upd_hit;
      logic          ptr_we;
      logic [AW-1:0] ptr_d;

      assign wr_hit  = wr_en && (wr_set == SW'(s)) && (wr_bank == 1'(b));
      assign upd_hit = upd_en && (upd_set == SW'(s)) && (upd_bank == 1'(b));

      always_comb begin
        ptr_we = 1'b0;
        ptr_d  = ptr_a[SL];
        if (wr_hit && (wr_field == FLD_PTR || wr_field == FLD_BASE)) begin
          ptr_we = 1'b1;
          ptr_d  = wr_data;
        end else if (upd_hit) begin
          ptr_we = 1'b1;
          ptr_d  = upd_ptr;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ptr_a[SL]  <= '0;
          step_a[SL] <= '0;
          base_a[SL] <= '0;
          size_a[SL] <= '0;
        end else begin
          if (ptr_we)                            ptr_a[SL]  <= ptr_d;
          if (wr_hit && wr_field == FLD_STEP)    step_a[SL] <= wr_data;
          if (wr_hit && wr_field == FLD_BASE)    base_a[SL] <= wr_data;
          if (wr_hit && wr_field == FLD_SIZE)    size_a[SL] <= wr_data;
        end
      end
    end
  end

  logic [SW:0] rd_slot;
  assign rd_slot = {rd_bank, rd_set};
  assign rd_ptr  = ptr_a[rd_slot];
  assign rd_step = step_a[rd_slot];
  assign rd_base = base_a[rd_slot];
  assign rd_size = size_a[rd_slot];
endmodule

// File: rtl/dag_wrap.sv
module dag_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] nxt_ptr
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum_x;
  logic signed [EW-1:0] lo_x;
  logic signed [EW-1:0] hi_x;
  logic signed [EW-1:0] size_x;

  always_comb begin
    sum_x  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    lo_x   = $signed({2'b00, base});
    size_x = $signed({2'b00, size});
    hi_x   = lo_x + size_x;
    if (size == '0) begin
      nxt_ptr = AW'(sum_x);
    end else if (sum_x >= hi_x) begin
      nxt_ptr = AW'(sum_x - size_x);
    end else if (sum_x < lo_x) begin
      nxt_ptr = AW'(sum_x + size_x);
    end else begin
      nxt_ptr = AW'(sum_x);
    end
  end
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
  parameter int AW  = 16,
  localparam int RBW = $clog2(AW + 1)
) (
  input  logic [AW-1:0]  din,
  input  logic [RBW-1:0] nbits,
  output logic [AW-1:0]  dout
);
  int n_eff;

  always_comb begin
    n_eff = (int'(nbits) > AW) ? AW : int'(nbits);
    dout  = din;
    for (int k = 0; k < AW; k++) begin
      if (k < n_eff) begin
        dout[k] = din[n_eff - 1 - k];
      end
    end
  end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
  import dag_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NSETS = 8,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int RBW  = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_set,
  input  logic           wr_bank,
  input  logic [1:0]     wr_field,
  input  logic [AW-1:0]  wr_data,
  input  logic           acc_en,
  input  logic [SW-1:0]  acc_set,
  input  logic           acc_bank,
  input  logic           acc_imm_en,
  input  logic [AW-1:0]  acc_imm,
  input  logic           acc_rev_en,
  input  logic [RBW-1:0] rev_bits,
  output logic [AW-1:0]  addr_out,
  output logic           addr_valid
);
  logic          rst_sync_n;
  logic [AW-1:0] sel_ptr;
  logic [AW-1:0] sel_step;
  logic [AW-1:0] sel_base;
  logic [AW-1:0] sel_size;
  logic [AW-1:0] eff_step;
  logic [AW-1:0] nxt_ptr;
  logic [AW-1:0] rev_ptr;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] addr_q;
  logic          valid_q;

  dag_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dag_regfile #(.AW(AW), .NSETS(NSETS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_bank  (wr_bank),
    .wr_field (dag_field_e'(wr_field)),
    .wr_data  (wr_data),
    .upd_en   (acc_en),
    .upd_set  (acc_set),
    .upd_bank (acc_bank),
    .upd_ptr  (nxt_ptr),
    .rd_set   (acc_set),
    .rd_bank  (acc_bank),
    .rd_ptr   (sel_ptr),
    .rd_step  (sel_step),
    .rd_base  (sel_base),
    .rd_size  (sel_size)
  );

  assign eff_step = acc_imm_en ? acc_imm : sel_step;

  dag_wrap #(.AW(AW)) u_wrap (
    .ptr     (sel_ptr),
    .step    (eff_step),
    .base    (sel_base),
    .size    (sel_size),
    .nxt_ptr (nxt_ptr)
  );

  dag_bitrev #(.AW(AW)) u_rev (
    .din   (sel_ptr),
    .nbits (rev_bits),
    .dout  (rev_ptr)
  );

  always_comb begin
    addr_d = addr_q;
    if (acc_en) begin
      addr_d = acc_rev_en ? rev_ptr : sel_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= acc_en;
      if (acc_en) addr_q <= addr_d;
    end
  end

  assign addr_out   = addr_q;
  assign addr_valid = valid_q;
endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_rev_en,
  input logic [AW-1:0] sel_ptr,
  input logic [AW-1:0] sel_base,
  input logic [AW-1:0] sel_size,
  input logic [AW-1:0] eff_step,
  input logic [AW-1:0] nxt_ptr,
  input logic [AW-1:0] addr_out,
  input logic          addr_valid
);
  logic [AW:0]   hi_bound;
  logic [AW-1:0] step_mag;
  logic          ptr_inside;
  logic          nxt_inside;
  logic          wrap_case;

  always_comb begin
    hi_bound   = {1'b0, sel_base} + {1'b0, sel_size};
    step_mag   = eff_step[AW-1] ? (~eff_step + 1'b1) : eff_step;
    ptr_inside = (sel_ptr >= sel_base) && ({1'b0, sel_ptr} < hi_bound);
    nxt_inside = (nxt_ptr >= sel_base) && ({1'b0, nxt_ptr} < hi_bound);
    wrap_case  = acc_en && (sel_size != '0) && ptr_inside && (step_mag <= sel_size);
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_valid);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(addr_out));

  // R3
  addr_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_rev_en) |=> (addr_out == $past(sel_ptr)));

  // R5 R6
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_case |-> nxt_inside);
endmodule

bind dag_addr_gen dag_addr_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .acc_en     (acc_en),
  .acc_rev_en (acc_rev_en),
  .sel_ptr    (sel_ptr),
  .sel_base   (sel_base),
  .sel_size   (sel_size),
  .eff_step   (eff_step),
  .nxt_ptr    (nxt_ptr),
  .addr_out   (addr_out),
  .addr_valid (addr_valid)
);

// File: tb/dag_addr_gen_bench.sv
module dag_addr_gen_bench;
  localparam int AW = 16;
  localparam int NS = 8;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_set;
  logic        wr_bank;
  logic [1:0]  wr_field;
  logic [15:0] wr_data;
  logic        acc_en;
  logic [2:0]  acc_set;
  logic        acc_bank;
  logic        acc_imm_en;
  logic [15:0] acc_imm;
  logic        acc_rev_en;
  logic [4:0]  rev_bits;
  logic [15:0] addr_out;
  logic        addr_valid;

  int n_chk;
  int n_bad;

  logic [15:0] mp [2][NS];
  logic [15:0] ms [2][NS];
  logic [15:0] mb [2][NS];
  logic [15:0] ml [2][NS];

  dag_addr_gen #(.AW(AW), .NSETS(NS)) u_dag_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_set(wr_set), .wr_bank(wr_bank), .wr_field(wr_field), .wr_data(wr_data),
    .acc_en(acc_en), .acc_set(acc_set), .acc_bank(acc_bank), .acc_imm_en(acc_imm_en),
    .acc_imm(acc_imm), .acc_rev_en(acc_rev_en), .rev_bits(rev_bits),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] m_next(logic [15:0] p, logic [15:0] s,
                                         logic [15:0] b, logic [15:0] l);
    int n;
    n = int'(p) + int'($signed(s));
    if (l != 16'd0) begin
      if (n >= int'(b) + int'(l)) n = n - int'(l);
      else if (n < int'(b))       n = n + int'(l);
    end
    return n[15:0];
  endfunction

  function automatic logic [15:0] m_rev(logic [15:0] p, int nb);
    logic [15:0] r;
    r = p;
    for (int k = 0; k < nb; k++) r[k] = p[nb - 1 - k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_wr(input int s, input int b, input int f, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = 3'(s); wr_bank = 1'(b); wr_field = 2'(f); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    case (f)
      0: mp[b][s] = d;
      1: ms[b][s] = d;
      2: begin mb[b][s] = d; mp[b][s] = d; end
      default: ml[b][s] = d;
    endcase
  endtask

  task automatic do_acc(input string tag, input int s, input int b, input bit ie,
                        input logic [15:0] imm, input bit rv, input int nb);
    logic [15:0] e;
    logic [15:0] st;
    e  = rv ? m_rev(mp[b][s], nb) : mp[b][s];
    st = ie ? imm : ms[b][s];
    @(negedge clk);
    acc_en = 1'b1; acc_set = 3'(s); acc_bank = 1'(b);
    acc_imm_en = ie; acc_imm = imm; acc_rev_en = rv; rev_bits = 5'(nb);
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0;
    chk(tag, addr_out, e);
    chk({tag, " valid"}, {15'd0, addr_valid}, 16'd1);
    mp[b][s] = m_next(mp[b][s], st, mb[b][s], ml[b][s]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] hold;
    void'($urandom(1234));
    n_chk = 0; n_bad = 0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++) begin
        mp[b][s] = 0; ms[b][s] = 0; mb[b][s] = 0; ml[b][s] = 0;
      end
    rst_n = 1'b0; wr_en = 0; wr_set = 0; wr_bank = 0; wr_field = 0; wr_data = 0;
    acc_en = 0; acc_set = 0; acc_bank = 0; acc_imm_en = 0; acc_imm = 0;
    acc_rev_en = 0; rev_bits = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", {15'd0, addr_valid}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 valid after reset", {15'd0, addr_valid}, 16'd0);
    chk("R1 addr after reset", addr_out, 16'd0);
    do_acc("R1 zero regs", 5, 1, 0, 0, 0, 0);
    do_acc("R1 zero regs again", 5, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 valid drops", {15'd0, addr_valid}, 16'd0);
    chk("R2 addr holds", addr_out, 16'd0);

    // R9 base loads pointer, R3 linear step
    do_wr(0, 0, 2, 16'h0100);
    do_acc("R9 base init", 0, 0, 0, 0, 0, 0);
    do_wr(0, 0, 1, 16'd3);
    do_acc("R3 step", 0, 0, 0, 0, 0, 0);
    do_acc("R3 step 2", 0, 0, 0, 0, 0, 0);
    chk("R3 model ptr", mp[0][0], 16'h0106);

    // R5 upper wrap
    do_wr(0, 0, 2, 16'h0100);
    do_wr(0, 0, 3, 16'd8);
    do_acc("R5 a", 0, 0, 0, 0, 0, 0);
    do_acc("R5 b", 0, 0, 0, 0, 0, 0);
    do_acc("R5 c", 0, 0, 0, 0, 0, 0);
    do_acc("R5 wrapped", 0, 0, 0, 0, 0, 0);
    chk("R5 expected 0x101 emitted", mp[0][0], 16'h0104);
    // R6 lower wrap via immediate, R4 stored step kept
    do_acc("R4 R6 imm -5", 0, 0, 1, 16'hFFFB, 0, 0);
    do_acc("R6 wrapped low", 0, 0, 0, 0, 0, 0);
    chk("R6 model", mp[0][0], 16'h0102);
    do_acc("R4 stored step kept", 0, 0, 0, 0, 0, 0);

    // R7 linear rollover
    do_wr(2, 0, 3, 16'd0);
    do_wr(2, 0, 0, 16'hFFFE);
    do_wr(2, 0, 1, 16'd5);
    do_acc("R7 a", 2, 0, 0, 0, 0, 0);
    do_acc("R7 rolled", 2, 0, 0, 0, 0, 0);

    // R8 bit reverse
    do_wr(3, 0, 0, 16'h0012);
    do_wr(3, 0, 1, 16'd1);
    do_acc("R8 rev4", 3, 0, 0, 0, 1, 4);
    do_acc("R8 rev16", 3, 0, 0, 0, 1, 16);
    do_acc("R8 linear kept", 3, 0, 0, 0, 0, 0);
    do_acc("R8 rev0", 3, 0, 0, 0, 1, 0);

    // R10 banks independent
    do_wr(0, 1, 2, 16'h0500);
    do_acc("R10 secondary", 0, 1, 0, 0, 0, 0);
    do_acc("R10 primary untouched", 0, 0, 0, 0, 0, 0);
    do_acc("R10 other set untouched", 3, 0, 0, 0, 0, 0);

    // R11 same-cycle write and access
    hold = mp[0][0];
    @(negedge clk);
    wr_en = 1; wr_set = 0; wr_bank = 0; wr_field = 2'd0; wr_data = 16'h0105;
    acc_en = 1; acc_set = 0; acc_bank = 0; acc_imm_en = 0; acc_rev_en = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; acc_en = 0;
    chk("R11 old ptr emitted", addr_out, hold);
    mp[0][0] = 16'h0105;
    do_acc("R11 write wins", 0, 0, 0, 0, 0, 0);

    // random windows
    for (int it = 0; it < 150; it++) begin
      int s; int b; int l; int bs; int st;
      s  = int'($urandom_range(NS - 1, 0));
      b  = int'($urandom_range(1, 0));
      l  = ($urandom_range(9, 0) == 0) ? 0 : int'($urandom_range(64, 1));
      bs = int'($urandom_range(60000, 0));
      st = (l == 0) ? int'($urandom_range(20, 0)) - 10
                    : int'($urandom_range(2 * l, 0)) - l;
      do_wr(s, b, 2, 16'(bs));
      do_wr(s, b, 3, 16'(l));
      do_wr(s, b, 1, 16'(st));
      for (int a = 0; a < 6; a++) begin
        bit ie; bit rv; int im;
        ie = ($urandom_range(3, 0) == 0);
        rv = ($urandom_range(2, 0) == 0);
        im = (l == 0) ? int'($urandom_range(20, 0)) - 10
                      : int'($urandom_range(2 * l, 0)) - l;
        do_acc(rv ? "R8 random rev" : (l == 0 ? "R7 random" : "R5 R6 random"),
               s, b, ie, 16'(im), rv, int'($urandom_range(16, 0)));
      end
      do_acc("R10 random other bank", s, 1 - b, 0, 0, 0, 0);
    end

    summary();
    $finish;
  end
endmodule